// File: doc/BRIEF.md
# Register window address translator

This block sits between a 128 MB host memory-mapped slave port and an internal register fabric. The host space splits into two parts. Addresses below 0x06000000 go to a memory port unchanged. Addresses from 0x06000000 up to the top of the space form the register region. Each of up to four host functions owns a one-bit window-select register. When a host function accesses the register region, that function's bit picks one of two internal register pages. The block forwards the access as a page bit followed by the offset within the region.

The PCIe register range is region offsets 0x00100000 to 0x001FFFFF. It is global: it reaches the fabric on page 0 whatever the selection is. The window-select registers are held inside this block and are not forwarded. They sit inside the global range, at host address 0x06110210 + f*0x20.

A request is registered on the clock edge, and the result appears on the outputs in the following cycle. A small state machine records what kind of access is in flight. It has four states:
- ST_IDLE: no request was presented.
- ST_MEM: an untranslated memory access.
- ST_REG: a translated fabric access.
- ST_SEL: a window-select register access.

On every edge the machine moves from its current state to the state named by the request presented in that cycle:
- A request below the region goes to ST_MEM.
- A request that exactly matches a select-register address goes to ST_SEL.
- Any other request inside the region goes to ST_REG.
- A cycle with no request goes to ST_IDLE.

Synchronous reset forces ST_IDLE.

Top module: `rwin_xlate`

## Requirements
- R1: After reset, every window-select bit is 0, all strobes are low and host_rdata is 0. A region access made right after reset therefore reaches page 0.
- R2: A request with address below 0x06000000 produces, one cycle later, mem_rd (read) or mem_wr (write) with mem_addr equal to the host address, and no fabric strobe.
- R3: A request in the region that is not a select-register address produces, one cycle later, reg_rd or reg_wr. Bits [24:0] of reg_addr equal the host address minus 0x06000000.
- R4: A host write to 0x06110210 + f*0x20 (f = 0..3) stores host_wdata bit 25 as function f's select bit and leaves the other functions' bits unchanged. Addresses that are not an exact match are ordinary region accesses.
- R5: A host read of function f's select register returns, one cycle later, 0x02000000 if the bit is set and 0 if it is clear. Select-register accesses raise no memory or fabric strobe.
- R6: A region access whose offset is in 0x00100000..0x001FFFFF drives reg_addr bit 25 to 0 regardless of the select bits.
- R7: Outside the global range, reg_addr bit 25 equals the select bit of the function given on host_func in the request cycle. A select write is visible to a request in the very next cycle.
- R8: host_rdata returns reg_rdata during a translated read cycle and mem_rdata during a memory read cycle. It is 0 during write cycles. fab_wdata carries the request's host_wdata while a write strobe is high.
- R9: A request with host_rd and host_wr both high is treated as a write. At most one of mem_rd, mem_wr, reg_rd and reg_wr is ever high.
- R10: A cycle with neither host_rd nor host_wr leaves all strobes low and host_rdata 0 in the next cycle, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_func | input | 2 | Host function issuing the request |
| host_addr | input | 27 | Host byte address in the 128 MB space |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data returned to the host, one cycle after the request |
| mem_addr | output | 27 | Untranslated memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data |
| reg_addr | output | 26 | Fabric address: page bit at 25, region offset below |
| reg_rd | output | 1 | Fabric read strobe |
| reg_wr | output | 1 | Fabric write strobe |
| reg_rdata | input | 32 | Fabric read data |
| fab_wdata | output | 32 | Write data for the memory port and the fabric |

## Verification
The hardest case to reach is an interaction between functions. One function sets its select bit, and in the very next cycle another function, or the same one, makes region accesses both inside and outside the global range. Two things must hold there: the page bit follows the issuing function, not the last writer, and the global range still forces page 0. The stimulus writes select registers with the other data bits set to garbage and follows each write at once with accesses from every function. It probes addresses one word away from each select register, including the nonexistent fifth one, and applies a reset in mid-run while bits are set. A long random phase then mixes all address classes with simultaneous read and write. A behavioural model follows every cycle.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;
    typedef enum logic [1:0] {
        KIND_MEM,
        KIND_REG,
        KIND_SEL
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_REG,
        ST_SEL
    } state_t;
endpackage

// File: rtl/rwin_decode.sv
`timescale 1ns/1ps
module rwin_decode
    import rwin_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int NUM_FUNC = 4,
    parameter logic [ADDR_W-1:0] REGION_BASE = 27'h600_0000,
    parameter logic [ADDR_W-1:0] SEL_BASE = 27'h611_0210,
    parameter logic [ADDR_W-1:0] SEL_STRIDE = 27'h20,
    parameter logic [ADDR_W-1:0] GLOB_LO = 27'h610_0000,
    parameter logic [ADDR_W-1:0] GLOB_HI = 27'h61F_FFFF,
    localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_t             kind,
    output logic [FUNC_W-1:0] sel_idx,
    output logic              glob_hit
);
    logic [NUM_FUNC-1:0] hit;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_selcmp
        localparam logic [ADDR_W-1:0] SEL_ADDR = SEL_BASE + SEL_STRIDE * ADDR_W'(f);
        assign hit[f] = (addr == SEL_ADDR);
    end

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM_FUNC; i++) begin
            if (hit[i]) sel_idx = FUNC_W'(i);
        end
    end

    always_comb begin
        if (addr < REGION_BASE)  kind = KIND_MEM;
        else if (|hit)           kind = KIND_SEL;
        else                     kind = KIND_REG;
    end

    assign glob_hit = (addr >= GLOB_LO) && (addr <= GLOB_HI);
endmodule

// File: rtl/rwin_selbank.sv
`timescale 1ns/1ps
module rwin_selbank #(
    parameter int NUM_FUNC = 4,
    localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [FUNC_W-1:0]   wr_idx,
    input  logic                wr_bit,
    output logic [NUM_FUNC-1:0] sel_q
);
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                                   sel_q[f] <= 1'b0;
            else if (wr_en && (wr_idx == FUNC_W'(f)))  sel_q[f] <= wr_bit;
        end
    end

    // R4: a write changes only the addressed function's bit
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sel_q[$past(wr_idx)] == $past(wr_bit)));
    a_r4_others_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((sel_q ^ $past(sel_q)) & ~(NUM_FUNC'(1) << $past(wr_idx))) == '0));
    a_r4_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/rwin_xlate.sv
`timescale 1ns/1ps
module rwin_xlate
    import rwin_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int DATA_W = 32,
    parameter int NUM_FUNC = 4,
    parameter int SEL_BIT = 25,
    parameter logic [ADDR_W-1:0] REGION_BASE = 27'h600_0000,
    parameter logic [ADDR_W-1:0] SEL_BASE = 27'h611_0210,
    parameter logic [ADDR_W-1:0] SEL_STRIDE = 27'h20,
    parameter logic [ADDR_W-1:0] GLOB_LO = 27'h610_0000,
    parameter logic [ADDR_W-1:0] GLOB_HI = 27'h61F_FFFF,
    localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1,
    localparam int OFF_W = $clog2((2 ** ADDR_W) - int'(REGION_BASE))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FUNC_W-1:0] host_func,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [OFF_W:0]    reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] fab_wdata
);
    kind_t               kind;
    logic [FUNC_W-1:0]   sel_idx;
    logic                glob_hit;
    logic [NUM_FUNC-1:0] sel_q;
    logic                req;
    logic                sel_wr_en;

    state_t              state_q, state_d;
    logic [ADDR_W-1:0]   cap_addr;
    logic [OFF_W-1:0]    cap_off;
    logic                cap_wr;
    logic [DATA_W-1:0]   cap_wdata;
    logic                cap_win;
    logic                cap_selbit;

    assign req       = host_rd | host_wr;
    assign sel_wr_en = req && host_wr && (kind == KIND_SEL);

    rwin_decode #(
        .ADDR_W(ADDR_W), .NUM_FUNC(NUM_FUNC), .REGION_BASE(REGION_BASE),
        .SEL_BASE(SEL_BASE), .SEL_STRIDE(SEL_STRIDE),
        .GLOB_LO(GLOB_LO), .GLOB_HI(GLOB_HI)
    ) u_decode (
        .addr(host_addr), .kind(kind), .sel_idx(sel_idx), .glob_hit(glob_hit)
    );

    rwin_selbank #(.NUM_FUNC(NUM_FUNC)) u_selbank (
        .clk(clk), .rst(rst), .wr_en(sel_wr_en), .wr_idx(sel_idx),
        .wr_bit(host_wdata[SEL_BIT]), .sel_q(sel_q)
    );

    // next-state: every edge takes the kind of the request presented
    always_comb begin
        state_d = ST_IDLE;
        if (req) begin
            unique case (kind)
                KIND_MEM: state_d = ST_MEM;
                KIND_REG: state_d = ST_REG;
                KIND_SEL: state_d = ST_SEL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cap_addr   <= '0;
            cap_off    <= '0;
            cap_wr     <= 1'b0;
            cap_wdata  <= '0;
            cap_win    <= 1'b0;
            cap_selbit <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req) begin
                cap_addr   <= host_addr;
                cap_off    <= OFF_W'(host_addr - REGION_BASE);
                cap_wr     <= host_wr;
                cap_wdata  <= host_wdata;
                cap_win    <= glob_hit ? 1'b0 : sel_q[host_func];
                cap_selbit <= sel_q[sel_idx];
            end
        end
    end

    // outputs decoded from the in-flight state
    always_comb begin
        host_rdata = '0;
        mem_addr   = cap_addr;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        reg_addr   = {cap_win, cap_off};
        reg_rd     = 1'b0;
        reg_wr     = 1'b0;
        fab_wdata  = cap_wdata;
        unique case (state_q)
            ST_IDLE: ;
            ST_MEM: begin
                mem_rd     = !cap_wr;
                mem_wr     = cap_wr;
                host_rdata = cap_wr ? '0 : mem_rdata;
            end
            ST_REG: begin
                reg_rd     = !cap_wr;
                reg_wr     = cap_wr;
                host_rdata = cap_wr ? '0 : reg_rdata;
            end
            ST_SEL: begin
                host_rdata = cap_wr ? '0 : (DATA_W'(cap_selbit) << SEL_BIT);
            end
            default: ;
        endcase
    end

    // R2: low addresses reach the memory port untranslated
    a_r2_mem_follows: assert property (@(posedge clk) disable iff (rst)
        (req && host_addr < REGION_BASE) |=>
            ((mem_rd || mem_wr) && mem_addr == $past(host_addr) && !reg_rd && !reg_wr));
    // R3: region offset is carried into the fabric address
    a_r3_reg_offset: assert property (@(posedge clk) disable iff (rst)
        (req && kind == KIND_REG) |=>
            ((reg_rd || reg_wr) && reg_addr[OFF_W-1:0] == OFF_W'($past(host_addr) - REGION_BASE)));
    // R5: select-register accesses stay local
    a_r5_sel_local: assert property (@(posedge clk) disable iff (rst)
        (req && kind == KIND_SEL) |=> !(mem_rd || mem_wr || reg_rd || reg_wr));
    // R6: global range always on page 0
    a_r6_global_page0: assert property (@(posedge clk) disable iff (rst)
        (req && kind == KIND_REG && glob_hit) |=> (reg_addr[OFF_W] == 1'b0));
    // R7: page bit follows the issuing function outside the global range
    a_r7_page_func: assert property (@(posedge clk) disable iff (rst)
        (req && kind == KIND_REG && !glob_hit) |=> (reg_addr[OFF_W] == $past(sel_q[host_func])));
    // R9: at most one strobe
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, reg_rd, reg_wr}));
    // R10: no request, no activity
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!mem_rd && !mem_wr && !reg_rd && !reg_wr && host_rdata == '0));
endmodule

// File: tb/rwin_xlate_tb.sv
`timescale 1ns/1ps
module rwin_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_func = '0;
    logic [26:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [26:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_rdata = '0;
    logic [25:0] reg_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_rdata = '0;
    logic [31:0] fab_wdata;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    rwin_xlate dut_i (
        .clk(clk), .rst(rst), .host_func(host_func), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
        .fab_wdata(fab_wdata)
    );

    // behavioural reference model
    bit          msel [4];
    bit          live = 0;
    bit          e_mem_rd, e_mem_wr, e_reg_rd, e_reg_wr;
    logic [26:0] e_mem_addr;
    logic [25:0] e_reg_addr;
    logic [31:0] e_wd, e_selv;
    int          e_src;
    string       e_tag;

    always @(posedge clk) begin
        int unsigned off;
        int fidx;
        live = 1;
        e_mem_rd = 0; e_mem_wr = 0; e_reg_rd = 0; e_reg_wr = 0; e_src = 0;
        e_tag = cur_req;
        if (rst) begin
            foreach (msel[i]) msel[i] = 0;
            e_tag = "R1";
        end else if (host_rd || host_wr) begin
            e_wd = host_wdata;
            if (host_addr < 27'h600_0000) begin
                e_mem_addr = host_addr;
                e_mem_wr = host_wr; e_mem_rd = !host_wr;
                e_src = host_wr ? 0 : 3;
            end else begin
                off = 32'(host_addr) - 32'h0600_0000;
                fidx = -1;
                for (int f = 0; f < 4; f++)
                    if (off == 32'h11_0210 + 32'(f) * 32'h20) fidx = f;
                if (fidx >= 0) begin
                    if (host_wr) msel[fidx] = host_wdata[25];
                    else begin
                        e_src = 1;
                        e_selv = msel[fidx] ? 32'h0200_0000 : 32'h0;
                    end
                end else begin
                    e_reg_addr = {((off >= 32'h10_0000 && off < 32'h20_0000) ? 1'b0 : msel[host_func]),
                                  off[24:0]};
                    e_reg_wr = host_wr; e_reg_rd = !host_wr;
                    e_src = host_wr ? 0 : 2;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", e_tag, what, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] er;
        if (live) begin
            chk("mem_rd", 32'(mem_rd), 32'(e_mem_rd));
            chk("mem_wr", 32'(mem_wr), 32'(e_mem_wr));
            chk("reg_rd", 32'(reg_rd), 32'(e_reg_rd));
            chk("reg_wr", 32'(reg_wr), 32'(e_reg_wr));
            if (e_mem_rd || e_mem_wr) chk("mem_addr", 32'(mem_addr), 32'(e_mem_addr));
            if (e_reg_rd || e_reg_wr) chk("reg_addr", 32'(reg_addr), 32'(e_reg_addr));
            if (e_mem_wr || e_reg_wr) chk("fab_wdata", fab_wdata, e_wd);
            case (e_src)
                1: er = e_selv;
                2: er = reg_rdata;
                3: er = mem_rdata;
                default: er = 32'h0;
            endcase
            chk("host_rdata", host_rdata, er);
        end
    end

    task automatic drive(input string tag, input int f, input logic [26:0] a,
                         input bit rd, input bit wr, input logic [31:0] wd);
        @(posedge clk); #1;
        cur_req = tag;
        host_func = f[1:0]; host_addr = a; host_rd = rd; host_wr = wr; host_wdata = wd;
        reg_rdata = $urandom; mem_rdata = $urandom;
    endtask

    task automatic idle(input string tag);
        drive(tag, int'($urandom_range(3)), 27'($urandom), 0, 0, $urandom);
    endtask

    function automatic logic [26:0] sel_addr(input int f);
        return 27'h611_0210 + 27'(f) * 27'h20;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: fresh reset, page 0 and zero select bits
        for (int f = 0; f < 4; f++) drive("R1", f, 27'h660_0000, 1, 0, 0);
        for (int f = 0; f < 4; f++) drive("R1", f, sel_addr(f), 1, 0, 0);
        // R2: memory port
        drive("R2", 0, 27'h000_0000, 1, 0, 0);
        drive("R2", 1, 27'h5FF_FFFC, 1, 0, 0);
        drive("R2", 2, 27'h123_4568, 0, 1, 32'hCAFE_0001);
        drive("R8", 3, 27'h040_0000, 1, 0, 0);
        // R3: region edges and blocks
        drive("R3", 0, 27'h600_0000, 1, 0, 0);
        drive("R3", 1, 27'h7FF_FFFC, 1, 0, 0);
        drive("R3", 2, 27'h760_0000, 0, 1, 32'h1111_2222);
        drive("R8", 0, 27'h730_0010, 1, 0, 0);
        // R4/R7: set function 1 and use it at once
        drive("R4", 0, sel_addr(1), 0, 1, 32'hFFFF_FFFF);
        drive("R7", 1, 27'h660_0000, 1, 0, 0);
        drive("R7", 0, 27'h660_0000, 1, 0, 0);
        drive("R7", 1, 27'h720_0004, 0, 1, 32'h0BAD_F00D);
        drive("R4", 2, sel_addr(3), 0, 1, 32'h0200_0000);
        drive("R4", 2, sel_addr(2), 0, 1, 32'hFDFF_FFFF);
        // R5: readback of every select register
        for (int f = 0; f < 4; f++) drive("R5", 0, sel_addr(f), 1, 0, 0);
        drive("R5", 3, sel_addr(1), 0, 1, 32'h0200_0000);
        // R4: near misses are ordinary accesses
        drive("R4", 1, sel_addr(0) + 27'd4, 1, 0, 0);
        drive("R4", 1, sel_addr(4), 1, 0, 0);
        drive("R4", 3, sel_addr(3) - 27'd4, 0, 1, 32'h0);
        drive("R7", 3, 27'h611_0300 + 27'h10_0000, 1, 0, 0);
        // R6: global range with page 1 selected
        drive("R6", 1, 27'h610_0000, 1, 0, 0);
        drive("R6", 1, 27'h61F_FFFC, 0, 1, 32'h5A5A_5A5A);
        drive("R6", 3, 27'h620_0000, 1, 0, 0);
        drive("R6", 3, 27'h60F_FFFC, 1, 0, 0);
        // R9: both strobes at once
        drive("R9", 1, 27'h660_0000, 1, 1, 32'h9999_0000);
        drive("R9", 0, 27'h010_0000, 1, 1, 32'h9999_0001);
        drive("R9", 0, sel_addr(0), 1, 1, 32'h0200_0000);
        drive("R5", 0, sel_addr(0), 1, 0, 0);
        // R10: idle cycles with stray addresses
        repeat (4) idle("R10");
        // R1: mid-run reset clears selections
        @(posedge clk); #1 rst = 1; cur_req = "R1"; host_rd = 0; host_wr = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        drive("R1", 1, 27'h660_0000, 1, 0, 0);
        drive("R1", 3, sel_addr(3), 1, 0, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int cls = int'($urandom_range(4));
            int f = int'($urandom_range(3));
            logic [26:0] a;
            bit rd = 1'($urandom);
            bit wr = 1'($urandom);
            case (cls)
                0: a = 27'($urandom_range(32'h5FF_FFFF)) & ~27'd3;
                1: a = sel_addr(int'($urandom_range(3)));
                2: a = 27'h610_0000 + (27'($urandom_range(32'hF_FFFF)) & ~27'd3);
                default: a = 27'h600_0000 + (27'($urandom_range(32'h1FF_FFFF)) & ~27'd3);
            endcase
            drive("R7", f, a, rd, wr, $urandom);
        end
        repeat (3) idle("R10");
        @(negedge clk); #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule